// File: doc/BRIEF.md
# CAN Low-Power Mode Sequencer

This block decides when a CAN controller may go to sleep and when it may report that it is awake again. A low-power request from software is held off until the count of queued transmissions reaches zero. Only then does the sleep status bit rise. While asleep, the block switches off reception, the mailboxes and the error counters, and it raises an interrupt if the mask allows it.

Waking is driven by the bus. A run of recessive bits, each marked by a bit-time strobe, is counted. Once the configured number is reached (eleven by default), the wake status bit rises and the sleep bit clears in the same cycle. The same count is needed once after reset, before the first wake report. Until then both status bits read zero. The two status bits are never high together.

Top module: `can_lpm_seq`

## Requirements
- R1: `sleep_st` rises only on the clock edge at which `lp_req` is 1 and `tx_pending` is 0, and it is 1 from the next cycle on. Frames keep flowing (R6) while `lp_req` waits on pending transmissions.
- R2: The edge that sets `sleep_st` clears `wake_st`.
- R3: `sleep_st` and `wake_st` are never both 1. After reset both read 0.
- R4: After reset, `wake_st` rises on the edge after the eleventh consecutive strobed recessive bit. A strobed bit is one with `bit_strobe`=1; `bus_bit`=1 is recessive and `bus_bit`=0 is dominant. A strobed dominant bit restarts the run at zero.
- R5: While asleep with `lp_req`=0, eleven consecutive strobed recessive bits set `wake_st` and clear `sleep_st` on the same edge. A dominant bit restarts the run.
- R6: `rx_en` and `mbox_en` are 0 exactly while `sleep_st` is 1, and 1 otherwise.
- R7: `err_cnt_en` is 0 exactly while `sleep_st` is 1, and 1 otherwise.
- R8: `irq` equals `sleep_st` AND `irq_mask_en` in the same cycle.
- R9: If `lp_req` falls before `tx_pending` reaches 0, no sleep entry occurs. `sleep_st` stays 0 and `wake_st` keeps its value.
- R10: While asleep with `lp_req` held at 1, recessive bits are not counted and `sleep_st` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lp_req | input | 1 | Software request for low-power mode |
| tx_pending | input | PEND_W | Number of transmissions still queued |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| bit_strobe | input | 1 | One-cycle pulse marking a bus bit sample |
| irq_mask_en | input | 1 | Enables the sleep interrupt |
| sleep_st | output | 1 | Sleep status |
| wake_st | output | 1 | Wake status |
| rx_en | output | 1 | Reception enable |
| err_cnt_en | output | 1 | Error-counter enable |
| mbox_en | output | 1 | Mailbox-active enable |
| irq | output | 1 | Sleep interrupt |

## Verification
A wrong run counter shows up as `wake_st` rising one or more strobes early or late. It can also fail to restart after a dominant bit. In either case the status bits part from the model on the very edge where the count should have ended. A wrong sleep decision shows up one cycle after the edge where `lp_req` and the pending count were sampled: `sleep_st` either rises while traffic is still pending or misses the entry. The enables and the interrupt follow `sleep_st` combinationally, so any fault in them differs from the model in the same cycle.

// File: rtl/can_lpm_pkg.sv
// Package: shared type for the low-power sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package can_lpm_pkg;

    // Coarse mode of the sequencer, derived from the two status flags and the request.
    typedef enum logic [1:0] {
        PH_BOOT        = 2'd0,
        PH_AWAKE       = 2'd1,
        PH_SLEEP_HELD  = 2'd2,
        PH_SLEEP_COUNT = 2'd3
    } lpm_phase_t;

    // Map the flags to a phase; BOOT covers the interval after reset before the first wake.
    function automatic lpm_phase_t phase_of(input logic sleep_q, input logic wake_q,
                                            input logic req);
        if (sleep_q)     return req ? PH_SLEEP_HELD : PH_SLEEP_COUNT;
        else if (wake_q) return PH_AWAKE;
        else             return PH_BOOT;
    endfunction

endpackage

// File: rtl/can_lpm_wake_cnt.sv
// Module: counter of consecutive strobed recessive bus bits.
// Does: raises run_done combinationally on the strobe that completes WAKE_BITS recessive bits.
// Assumes: bit_strobe is a one-cycle pulse; bus_bit = 1 means recessive.
module can_lpm_wake_cnt #(
    parameter int WAKE_BITS = 11,
    localparam int CW = $clog2(WAKE_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic clr,
    input  logic bit_strobe,
    input  logic bus_bit,
    output logic run_done
);
    localparam logic [CW-1:0] LAST = CW'(WAKE_BITS - 1);

    logic [CW-1:0] run_q;
    logic          at_last;

    // Flag the strobe position that would complete the run.
    assign at_last  = (run_q == LAST);
    assign run_done = count_en && !clr && bit_strobe && bus_bit && at_last;

    // Track the length of the current recessive run, restarting on dominant or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clr || !count_en) begin
            run_q <= '0;
        end else if (bit_strobe) begin
            if (!bus_bit || at_last) run_q <= '0;
            else                     run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/can_lpm_ctrl.sv
// Module: sleep/wake status controller.
// Does: sets SLEEP once the request meets an idle transmit queue; sets WAKE when the run counter completes.
// Assumes: tx_idle is the decoded "no pending transmissions" condition of the current cycle.
module can_lpm_ctrl
    import can_lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_req,
    input  logic       tx_idle,
    input  logic       run_done,
    output logic       sleep_q,
    output logic       wake_q,
    output logic       enter_sleep,
    output logic       count_en
);
    lpm_phase_t phase;

    // Classify the present mode.
    assign phase = phase_of(sleep_q, wake_q, lp_req);

    // Sleep entry takes priority over a completing wake run.
    assign enter_sleep = !sleep_q && lp_req && tx_idle;

    // Count only in boot or in sleep with the request released.
    assign count_en = (phase == PH_BOOT) || (phase == PH_SLEEP_COUNT);

    // Update the exclusive status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q <= 1'b0;
            wake_q  <= 1'b0;
        end else if (enter_sleep) begin
            sleep_q <= 1'b1;
            wake_q  <= 1'b0;
        end else if (run_done) begin
            sleep_q <= 1'b0;
            wake_q  <= 1'b1;
        end
    end
endmodule

// File: rtl/can_lpm_out_gate.sv
// Module: output enables and interrupt gate.
// Does: turns the sleep flag into the disable controls and the masked interrupt.
// Assumes: purely combinational; sleep_q comes from a register.
module can_lpm_out_gate (
    input  logic sleep_q,
    input  logic irq_mask_en,
    output logic rx_en,
    output logic err_cnt_en,
    output logic mbox_en,
    output logic irq
);
    // Everything active is stopped while asleep.
    assign rx_en      = !sleep_q;
    assign err_cnt_en = !sleep_q;
    assign mbox_en    = !sleep_q;
    // Interrupt follows the sleep level when unmasked.
    assign irq        = sleep_q && irq_mask_en;
endmodule

// File: rtl/can_lpm_seq.sv
// Module: top of the CAN low-power mode sequencer.
// Does: joins the run counter, status controller and output gate.
// Assumes: synchronous active-low reset; inputs are synchronous to clk.
module can_lpm_seq #(
    parameter int WAKE_BITS = 11,
    parameter int PEND_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_req,
    input  logic [PEND_W-1:0] tx_pending,
    input  logic              bus_bit,
    input  logic              bit_strobe,
    input  logic              irq_mask_en,
    output logic              sleep_st,
    output logic              wake_st,
    output logic              rx_en,
    output logic              err_cnt_en,
    output logic              mbox_en,
    output logic              irq
);
    logic tx_idle;
    logic run_done;
    logic enter_sleep;
    logic count_en;

    // Queue is drained when no transmission is pending.
    assign tx_idle = (tx_pending == '0);

    can_lpm_wake_cnt #(.WAKE_BITS(WAKE_BITS)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en   (count_en),
        .clr        (enter_sleep),
        .bit_strobe (bit_strobe),
        .bus_bit    (bus_bit),
        .run_done   (run_done)
    );

    can_lpm_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .lp_req      (lp_req),
        .tx_idle     (tx_idle),
        .run_done    (run_done),
        .sleep_q     (sleep_st),
        .wake_q      (wake_st),
        .enter_sleep (enter_sleep),
        .count_en    (count_en)
    );

    can_lpm_out_gate u_gate (
        .sleep_q     (sleep_st),
        .irq_mask_en (irq_mask_en),
        .rx_en       (rx_en),
        .err_cnt_en  (err_cnt_en),
        .mbox_en     (mbox_en),
        .irq         (irq)
    );
endmodule

// File: rtl/can_lpm_seq_chk.sv
// Module: assertion checker for can_lpm_seq, attached by bind.
// Assumes: same parameters as the top; reads only top-level ports.
module can_lpm_seq_chk #(
    parameter int WAKE_BITS = 11,
    parameter int PEND_W    = 6,
    localparam int RW = $clog2(WAKE_BITS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lp_req,
    input logic [PEND_W-1:0] tx_pending,
    input logic              bus_bit,
    input logic              bit_strobe,
    input logic              irq_mask_en,
    input logic              sleep_st,
    input logic              wake_st,
    input logic              rx_en,
    input logic              err_cnt_en,
    input logic              mbox_en,
    input logic              irq
);
    logic [RW-1:0] rec_run;

    // Saturating length of the current recessive run seen on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rec_run <= '0;
        else if (bit_strobe && !bus_bit) rec_run <= '0;
        else if (bit_strobe && rec_run != RW'(WAKE_BITS)) rec_run <= rec_run + 1'b1;
    end

    AST_SLEEP_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_st) |-> $past(lp_req && tx_pending == '0));                  // R1
    AST_SLEEP_CLEARS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_st) |-> !wake_st);                                            // R2
    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sleep_st && wake_st));                                                  // R3
    AST_WAKE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_st) |-> rec_run == RW'(WAKE_BITS));                            // R4
    AST_WAKE_CLEARS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_st) |-> !sleep_st);                                            // R5
    AST_RX_MBOX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en == !sleep_st) && (mbox_en == !sleep_st));                          // R6
    AST_ERR_CNT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt_en == !sleep_st);                                                 // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (sleep_st && irq_mask_en));                                        // R8
    AST_HELD_STAYS_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_st && lp_req) |=> sleep_st);                                       // R10
endmodule

bind can_lpm_seq can_lpm_seq_chk #(.WAKE_BITS(WAKE_BITS), .PEND_W(PEND_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .tx_pending(tx_pending),
    .bus_bit(bus_bit), .bit_strobe(bit_strobe), .irq_mask_en(irq_mask_en),
    .sleep_st(sleep_st), .wake_st(wake_st), .rx_en(rx_en),
    .err_cnt_en(err_cnt_en), .mbox_en(mbox_en), .irq(irq)
);

// File: tb/can_lpm_seq_bench.sv
module can_lpm_seq_bench;
    localparam int WB = 11;
    localparam int PW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_req = 1'b0;
    logic [PW-1:0] tx_pending = '0;
    logic bus_bit = 1'b1;
    logic bit_strobe = 1'b0;
    logic irq_mask_en = 1'b0;
    logic sleep_st, wake_st, rx_en, err_cnt_en, mbox_en, irq;

    int checks = 0;
    int fails = 0;
    int m_sleep = 0;
    int m_wake = 0;
    int m_run = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    can_lpm_seq #(.WAKE_BITS(WB), .PEND_W(PW)) u_can_lpm_seq (
        .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .tx_pending(tx_pending),
        .bus_bit(bus_bit), .bit_strobe(bit_strobe), .irq_mask_en(irq_mask_en),
        .sleep_st(sleep_st), .wake_st(wake_st), .rx_en(rx_en),
        .err_cnt_en(err_cnt_en), .mbox_en(mbox_en), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model of one clock edge, from the requirements.
    task automatic model_edge();
        bit counting;
        if (!rst_n) begin
            m_sleep = 0; m_wake = 0; m_run = 0;
        end else if (m_sleep == 0 && lp_req && tx_pending == 0) begin
            m_sleep = 1; m_wake = 0; m_run = 0;
        end else begin
            counting = (m_wake == 0) && !(m_sleep == 1 && lp_req);
            if (!counting) m_run = 0;
            else if (bit_strobe) begin
                if (!bus_bit) m_run = 0;
                else if (m_run == WB - 1) begin m_wake = 1; m_sleep = 0; m_run = 0; end
                else m_run++;
            end
        end
    endtask

    // Advance one cycle and compare every output against the model.
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R1 sleep_st", int'(sleep_st), m_sleep);
        chk("R4 wake_st", int'(wake_st), m_wake);
        chk("R3 exclusive", int'(sleep_st && wake_st), 0);
        chk("R6 rx_en", int'(rx_en), 1 - m_sleep);
        chk("R6 mbox_en", int'(mbox_en), 1 - m_sleep);
        chk("R7 err_cnt_en", int'(err_cnt_en), 1 - m_sleep);
        chk("R8 irq", int'(irq), (m_sleep == 1 && irq_mask_en) ? 1 : 0);
    endtask

    // Send n strobed bits of one level, one idle cycle between them.
    task automatic send_bits(input int n, input logic lvl);
        for (int i = 0; i < n; i++) begin
            bus_bit = lvl; bit_strobe = 1'b1;
            tick();
            bit_strobe = 1'b0;
            tick();
        end
        bus_bit = 1'b1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        chk("R3 reset sleep", int'(sleep_st), 0);
        chk("R3 reset wake", int'(wake_st), 0);
        rst_n = 1'b1;
        tick();
        // R4: partial run broken by dominant, then a full run.
        send_bits(6, 1'b1);
        send_bits(1, 1'b0);
        send_bits(10, 1'b1);
        chk("R4 not yet awake", int'(wake_st), 0);
        send_bits(1, 1'b1);
        chk("R4 awake after 11", int'(wake_st), 1);
        // R9: request with pending traffic, then withdraw.
        tx_pending = 3; lp_req = 1'b1;
        repeat (5) tick();
        chk("R1 rx during drain", int'(rx_en), 1);
        lp_req = 1'b0; tx_pending = 0;
        repeat (3) tick();
        chk("R9 cancel sleep", int'(sleep_st), 0);
        chk("R9 cancel wake kept", int'(wake_st), 1);
        // R1/R2: drain to zero then sleep.
        irq_mask_en = 1'b1;
        tx_pending = 2; lp_req = 1'b1;
        tick(); tx_pending = 1; tick(); tx_pending = 0;
        tick();
        chk("R1 sleep entered", int'(sleep_st), 1);
        chk("R2 wake cleared", int'(wake_st), 0);
        chk("R8 irq unmasked", int'(irq), 1);
        irq_mask_en = 1'b0;
        tick();
        chk("R8 irq masked", int'(irq), 0);
        // R10: held request ignores recessive bits.
        send_bits(20, 1'b1);
        chk("R10 still asleep", int'(sleep_st), 1);
        // R5: release and count, with a restart.
        lp_req = 1'b0;
        send_bits(8, 1'b1);
        send_bits(1, 1'b0);
        send_bits(10, 1'b1);
        chk("R5 asleep before run ends", int'(sleep_st), 1);
        send_bits(1, 1'b1);
        chk("R5 awake", int'(wake_st), 1);
        chk("R5 sleep cleared", int'(sleep_st), 0);
        // R1 from boot: reset then sleep immediately with empty queue.
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        lp_req = 1'b1; tick();
        chk("R1 sleep from boot", int'(sleep_st), 1);
        lp_req = 1'b0; send_bits(11, 1'b1);
        chk("R5 wake from boot sleep", int'(wake_st), 1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule